// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-word SPI master behind a three-register host bus. Software
programs a control word that selects the enable, the word length, the clock polarity
and phase, two interrupt sources and a serial clock divider. It then writes a word to
the data location to launch one full-duplex exchange. When the exchange ends, the
received word waits in a one-word holding register until the host reads it from the
same data location.

Status shows whether a shift is running and whether an unread word is waiting. A single
level interrupt combines a "word received" source and a "ready for the next write"
source. A receive-only exchange uses the same path: the host writes zero words to
produce clocks. Every exchange captures the input line. Chip selects are handled
outside the block.

Top module: `spi_host`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, and `spi_sclk`, `spi_mosi` and `spi_irq` are low.
- R2: The control word sits at byte offset 2. Bit 0 is enable, bit 2 is the word length (0 = 8 bits, 1 = 16 bits), bit 5 is the receive interrupt enable, bit 6 is the write-ready interrupt enable, bit 7 is clock polarity, bit 8 is clock phase and bits 15:9 are the divider. Bits 1, 3 and 4 always read zero.
- R3: A write to offset 0 while enabled and idle starts an exchange. Status bit 0 (busy, at offset 4) reads one from the next cycle and stays one for exactly 2·N·(div+1) cycles, where N is the word length.
- R4: When idle, `spi_sclk` rests at the polarity bit. During an exchange it toggles once every div+1 cycles, 2·N times in all, and ends at its rest level.
- R5: Data moves most significant bit first. With phase 0 both sides sample on the leading clock edge. With phase 1 both sides sample on the trailing edge. The four polarity/phase combinations give mode 0 (no bits), mode 1 (bit 8), mode 2 (bit 7) and mode 3 (both bits).
- R6: In 8-bit mode only the low byte of the written word is shifted out, and the received byte reads back zero-extended in bits 7:0.
- R7: Status bit 1 (receive full) sets in the cycle an exchange ends. A read of offset 0 returns the received word and clears the bit.
- R8: A write to offset 0 while busy, or while not enabled, has no effect on the exchange, the received word or the status.
- R9: Clearing the enable bit ends any exchange within one cycle. Busy clears, `spi_sclk` returns to its rest level and `spi_mosi` goes low. Receive full is not set, and the held received word and the other control fields are kept.
- R10: `spi_irq` is high exactly when (receive interrupt enable and receive full) or (write-ready interrupt enable and enabled and not busy).
- R11: `spi_mosi` is low whenever no exchange is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Byte offset of the register accessed |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_ren | input | 1 | Read strobe; a read of offset 0 clears receive full |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_irq | output | 1 | Level interrupt |

## Verification
A wrong edge counter or divider count shows at the status port as a busy window that is
too long or too short. It also shows as a serial clock left away from its rest level
once the exchange ends, so the error is visible in the first cycle after the exchange.
A wrong sample or launch edge choice corrupts the word returned by the data read and the
word seen by the bench's serial model, as soon as that exchange completes. A stale
receive-full or enable state shows at once on `spi_irq` and in the status bits, so each
exchange is checked for cycle length, line levels, both data directions and interrupt
level.

// File: rtl/spi_host_pkg.sv
// Package: shared register offsets, control word layout and widths for spi_host.
// Assumes a 16-bit register file addressed by byte offset.
package spi_host_pkg;
    localparam int REG_W  = 16;
    localparam int DIV_W  = 7;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

    // Control word, most significant field first; bit positions are software-visible.
    typedef struct packed {
        logic [DIV_W-1:0] div;     // 15:9
        logic             cpha;    // 8
        logic             cpol;    // 7
        logic             ie_wr;   // 6
        logic             ie_rx;   // 5
        logic [1:0]       rsv_hi;  // 4:3
        logic             wide;    // 2
        logic             rsv_lo;  // 1
        logic             en;      // 0
    } ctrl_t;

    // Writable control bits: 15..5, 2, 0.
    localparam logic [REG_W-1:0] CTRL_WMASK = 16'hFFE5;
endpackage

// File: rtl/spi_host_clkgen.sv
// Module: half-period tick generator. While run is high it pulses tick once
// every div+1 cycles; the counter restarts whenever run is low.
module spi_host_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_host_shifter.sv
// Module: one-word full-duplex shift engine. On start it loads the word and
// then, on each tick, toggles the serial clock; it launches and samples bits
// per the phase setting. Assumes start only while idle and no control change
// mid-exchange. fin pulses in the cycle of the final clock edge.
module spi_host_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              abort,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              fin,
    output logic [WORD_W-1:0] rx_word
);
    localparam int HALF   = WORD_W / 2;
    localparam int EDGE_W = $clog2(2 * WORD_W);

    logic [EDGE_W-1:0] edge_idx, last_idx;
    logic [WORD_W-1:0] tx_sr, rx_sr, tx_aligned, rx_shifted, rx_last, rx_fmt;
    logic              lead, sample_now, launch_now, is_last;

    // Decode the current edge and form the aligned and finished words.
    always_comb begin
        last_idx   = wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(WORD_W - 1);
        is_last    = (edge_idx == last_idx);
        lead       = ~edge_idx[0];
        sample_now = busy && tick && (lead ^ cpha);
        launch_now = busy && tick && !(lead ^ cpha) && !is_last;
        fin        = busy && tick && is_last && !abort;
        tx_aligned = wide ? tx_word : {tx_word[HALF-1:0], {(WORD_W-HALF){1'b0}}};
        rx_shifted = {rx_sr[WORD_W-2:0], miso};
        rx_last    = sample_now ? rx_shifted : rx_sr;
        rx_fmt     = wide ? rx_last : {{(WORD_W-HALF){1'b0}}, rx_last[HALF-1:0]};
    end

    // Sequence one exchange: load, toggle, launch, sample, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            edge_idx <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rx_word  <= '0;
        end else if (abort) begin
            busy     <= 1'b0;
            sclk     <= cpol;
            mosi     <= 1'b0;
            edge_idx <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            sclk     <= cpol;
            edge_idx <= '0;
            rx_sr    <= '0;
            if (!cpha) begin
                mosi  <= tx_aligned[WORD_W-1];
                tx_sr <= tx_aligned << 1;
            end else begin
                mosi  <= 1'b0;
                tx_sr <= tx_aligned;
            end
        end else if (busy) begin
            if (tick) begin
                sclk     <= ~sclk;
                edge_idx <= edge_idx + 1'b1;
                if (sample_now) rx_sr <= rx_shifted;
                if (launch_now) begin
                    mosi  <= tx_sr[WORD_W-1];
                    tx_sr <= tx_sr << 1;
                end
                if (is_last) begin
                    busy    <= 1'b0;
                    mosi    <= 1'b0;
                    rx_word <= rx_fmt;
                end
            end
        end else begin
            sclk <= cpol;
        end
    end
endmodule

// File: rtl/spi_host.sv
// Module: SPI master top. Holds the control register and the receive-full
// flag, decodes host accesses and drives the interrupt. Assumes one-cycle
// write/read strobes and combinational read data.
module spi_host
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic              reg_ren,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_irq
);
    ctrl_t             ctl_q;
    logic              rxfull, busy, fin, tick, start, rd_clr;
    logic              sel_data, sel_ctrl, sel_stat;
    logic [REG_W-1:0]  rx_word;

    assign sel_data = (reg_addr == OFS_DATA);
    assign sel_ctrl = (reg_addr == OFS_CTRL);
    assign sel_stat = (reg_addr == OFS_STAT);
    assign start    = reg_wen && sel_data && ctl_q.en && !busy;
    assign rd_clr   = reg_ren && sel_data;

    // Control register: masked host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctl_q <= '0;
        else if (reg_wen && sel_ctrl) ctl_q <= ctrl_t'(reg_wdata & CTRL_WMASK);
    end

    // Receive-full flag: set at exchange end, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rxfull <= 1'b0;
        else if (fin)    rxfull <= 1'b1;
        else if (rd_clr) rxfull <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (sel_data)      reg_rdata = rx_word;
        else if (sel_ctrl) reg_rdata = ctl_q;
        else if (sel_stat) reg_rdata = {{(REG_W-2){1'b0}}, rxfull, busy};
    end

    assign spi_irq = (ctl_q.ie_rx && rxfull) || (ctl_q.ie_wr && ctl_q.en && !busy);

    spi_host_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (ctl_q.div),
        .tick  (tick)
    );

    spi_host_shifter #(.WORD_W(REG_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .abort   (!ctl_q.en),
        .cpol    (ctl_q.cpol),
        .cpha    (ctl_q.cpha),
        .wide    (ctl_q.wide),
        .tx_word (reg_wdata),
        .miso    (spi_miso),
        .busy    (busy),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .fin     (fin),
        .rx_word (rx_word)
    );
endmodule

// File: rtl/spi_host_sva.sv
// Module: property checker for spi_host, attached by bind. Observes the
// register state, the shift engine status and the serial pins.
module spi_host_sva (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic en,
    input logic cpol,
    input logic ie_rx,
    input logic sclk,
    input logic mosi,
    input logic start,
    input logic rd_clr,
    input logic fin,
    input logic rxfull,
    input logic irq
);
    // R4: at rest the serial clock sits at the polarity level.
    p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $stable(cpol)) |-> (sclk == cpol));

    // R11: no data driven while idle.
    p_idle_mosi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    // R3: an accepted data write makes the block busy next cycle.
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: with enable cleared, busy is gone one cycle later.
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    // R7: a data read with no exchange ending clears receive full.
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !fin) |=> !rxfull);

    // R7: an ending exchange leaves receive full set.
    p_fin_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> rxfull);

    // R10: no interrupt while shifting with the receive source masked.
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ie_rx) |-> !irq);
endmodule

bind spi_host spi_host_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .en     (ctl_q.en),
    .cpol   (ctl_q.cpol),
    .ie_rx  (ctl_q.ie_rx),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .start  (start),
    .rd_clr (rd_clr),
    .fin    (fin),
    .rxfull (rxfull),
    .irq    (spi_irq)
);

// File: tb/test_spi_host.sv
// Bench: directed corners plus seeded random exchanges against a serial
// peer model; expected values come from the requirement formulas.
module test_spi_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic        reg_ren = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_irq;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // Serial peer state.
    logic        s_active = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0;
    logic [15:0] s_sr = '0, s_rx = '0;
    logic        sclk_prev = 1'b0, mosi_prev = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    spi_host i_spi_host (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_irq(spi_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl_word(input logic en, wide, rie, wie,
                                             cpol, cpha, input int div);
        logic [6:0] d = 7'(div);
        return {d, cpha, cpol, wie, rie, 2'b00, wide, 1'b0, en};
    endfunction

    // Peer: mid-cycle view of the lines; uses the data level held before each edge.
    initial forever begin
        @(negedge clk);
        if (s_active && spi_sclk !== sclk_prev) begin
            if ((spi_sclk != s_cpol) ^ s_cpha) s_rx = {s_rx[14:0], mosi_prev};
            else begin
                spi_miso = s_sr[15];
                s_sr     = s_sr << 1;
            end
        end
        sclk_prev = spi_sclk;
        mosi_prev = spi_mosi;
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a; reg_ren = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_ren = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One exchange with all checks; optional write during busy (R8).
    task automatic xfer(input logic wide, cpol, cpha, rie, wie, input int div,
                        input logic [15:0] tx, stx, input logic poke);
        logic [15:0] v, aligned;
        int cyc, exp_cyc;
        bus_write(3'h2, ctl_word(1'b1, wide, rie, wie, cpol, cpha, div));
        idle(1);
        aligned = wide ? stx : {stx[7:0], 8'h00};
        s_cpol = cpol; s_cpha = cpha; s_rx = '0;
        if (!cpha) begin spi_miso = aligned[15]; s_sr = aligned << 1; end
        else       begin s_sr = aligned; end
        s_active = 1'b1;
        bus_write(3'h0, tx);
        exp_cyc = (wide ? 32 : 16) * (div + 1);
        cyc = 1;
        peek(3'h4, v);
        chk("R3 busy after start", int'(v[0]), 1);
        chk("R10 irq while busy", int'(spi_irq), 0);
        if (poke) begin
            bus_write(3'h0, ~tx);
            cyc++;
            peek(3'h4, v);
        end
        while (v[0] && cyc < 20000) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            peek(3'h4, v);
        end
        s_active = 1'b0;
        chk("R3 busy length", cyc - 1, exp_cyc);
        chk("R7 full at end", int'(v[1]), 1);
        chk("R4 sclk at rest", int'(spi_sclk), int'(cpol));
        chk("R11 mosi low", int'(spi_mosi), 0);
        chk("R10 irq idle", int'(spi_irq), int'(rie | wie));
        bus_read(3'h0, v);
        chk(wide ? "R5 rx word" : "R6 rx byte", int'(v), wide ? int'(stx) : int'(stx[7:0]));
        chk(wide ? "R5 peer rx" : "R6 peer rx", int'(wide ? s_rx : {8'h00, s_rx[7:0]}),
            wide ? int'(tx) : int'(tx[7:0]));
        peek(3'h4, v);
        chk("R7 full cleared", int'(v[1]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        peek(3'h0, v); chk("R1 data", int'(v), 0);
        peek(3'h2, v); chk("R1 ctrl", int'(v), 0);
        peek(3'h4, v); chk("R1 stat", int'(v), 0);
        chk("R1 sclk", int'(spi_sclk), 0);
        chk("R1 mosi", int'(spi_mosi), 0);
        chk("R1 irq", int'(spi_irq), 0);
        // R8 data write while disabled
        bus_write(3'h0, 16'hA5A5);
        idle(1);
        peek(3'h4, v); chk("R8 disabled write stat", int'(v), 0);
        peek(3'h0, v); chk("R8 disabled write data", int'(v), 0);
        // R2 control layout
        bus_write(3'h2, 16'hFFFF);
        peek(3'h2, v); chk("R2 ctrl mask", int'(v), 16'hFFE5);
        chk("R10 write-ready irq", int'(spi_irq), 1);
        bus_write(3'h2, 16'h0000);
        idle(1);
        // Directed corners: each mode, both sizes, slowest divider
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'h8001, 16'h7FFE, 1'b0); // mode 0
        xfer(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2, 16'hC3A5, 16'h5A3C, 1'b0); // mode 1
        xfer(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 16'h1234, 16'hFEDC, 1'b0); // mode 2
        xfer(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3, 16'hFFFF, 16'h0000, 1'b0); // mode 3
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'hAB96, 16'hCD69, 1'b0); // R6
        xfer(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 16'h0081, 16'h0042, 1'b0); // R6
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 127, 16'h0000, 16'hB00B, 1'b0); // slowest
        xfer(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2, 16'h6C39, 16'h93C6, 1'b1); // R8 busy write
        // R9 abort mid-exchange
        bus_write(3'h2, ctl_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3));
        idle(1);
        bus_write(3'h0, 16'hF0F0);
        idle(5);
        bus_write(3'h2, ctl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3));
        idle(1);
        peek(3'h4, v); chk("R9 abort stat", int'(v), 0);
        chk("R9 abort sclk", int'(spi_sclk), 1);
        chk("R9 abort mosi", int'(spi_mosi), 0);
        peek(3'h2, v); chk("R9 fields kept", int'(v),
            int'(ctl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3)));
        peek(3'h0, v); chk("R9 held word kept", int'(v), 16'h93C6);
        // Seeded random exchanges
        for (int i = 0; i < 30; i++) begin
            xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 6), 16'($urandom), 16'($urandom), 1'b0);
        end
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule